// File: doc/BRIEF.md
# Looped Sample Playback Engine with Even-Step Rate Divider

This block plays an arbitrary waveform, held as a table of samples, out to a digital-to-analog converter. A host fills a sample memory through a dedicated write port, chooses how many leading entries form one playback loop, and chooses a rate code. The rate code divides the fast base clock either by one (full speed) or by an even integer. Every divided tick emits exactly one sample. The address counter climbs from 0 to the last active entry and then returns to 0, and it repeats this for as long as the block runs. No waveform shapes are built in, so every sample comes from the host.

The output frequency is the tick rate divided by the loop length in samples, times the number of waveform cycles the host stored in the loop. Either the loop length or the rate code can be rewritten on its own, without reloading the samples. Both values are staged and only adopted when the address wraps. A rate change therefore never restarts the loop or cuts it short, which lets a host sweep frequency by stepping the rate code alone. An optional compatibility flag reproduces a known divider quirk: when the divisor is not one, each loop is one base-clock cycle shorter. A one-tick sync flag marks the emission of address 0.

The divider is a clock-enable counter on the base clock, so the whole block lives in a single clock domain.

Top module: `wave_player`

## Requirements
- R1: A pulse on `mem_we` stores `mem_wdata` at `mem_addr` only when `load_en` is 1. With `load_en` at 0 the write has no effect on the samples that are played.
- R2: Each tick emits one sample on `dac_data`, marked by a one-cycle `dac_valid` pulse. Samples come from addresses 0, 1, …, N−1 and then 0 again, with no gap and no repeat.
- R3: The loop length N is taken from the last value written through `npts_we`. A value of 0 acts as 1, and values above DEPTH act as DEPTH.
- R4: The rate code h written through `div_we` gives one tick per base-clock cycle when h = 0, and one tick every 2·h cycles when h ≥ 1. The loop therefore lasts N·max(1, 2h) cycles.
- R5: When the compatibility flag written with the rate code is 1 and h ≥ 1, each loop lasts N·2h − 1 cycles, because the gap after the last sample of the loop is one cycle shorter. When h = 0 the flag has no effect.
- R6: A new loop length, rate code or compatibility flag is adopted only at the tick that emits the last active address. Until then, tick spacing and loop length follow the old values, and a write never restarts the address sequence.
- R7: `dac_sync` is 1 for exactly the `dac_valid` cycle that carries the sample from address 0, and is 0 in every other cycle.
- R8: While reset is asserted, `dac_valid`, `dac_sync` and `dac_data` are 0. After reset the loop length is 1, the rate code is 0 and the flag is 0. Memory contents are kept through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_en | input | 1 | Allows sample memory writes when 1 |
| mem_we | input | 1 | Sample write strobe |
| mem_addr | input | ADDR_W | Sample write address |
| mem_wdata | input | SAMPLE_W | Sample write data |
| npts_we | input | 1 | Stages a new loop length |
| npts_wdata | input | NPTS_W | Requested loop length in samples |
| div_we | input | 1 | Stages a new rate code and compatibility flag |
| div_half | input | HALF_W | Rate code h (divisor 1 when 0, else 2h) |
| div_compat | input | 1 | Compatibility flag, one cycle shorter loop |
| dac_data | output | SAMPLE_W | Current output sample |
| dac_valid | output | 1 | One-cycle pulse per emitted sample |
| dac_sync | output | 1 | Marks the sample from address 0 |

## Verification
The bench builds the block with DEPTH = 16, SAMPLE_W = 8 and HALF_W = 4, so a whole loop lasts at most a few dozen cycles. This makes it cheap to measure the exact cycle count between sync pulses and to compare every sample of a loop against a model of the memory. The small depth also puts both clamp edges within reach (requests of 0, 17 and 31 against 16 entries), and the narrow rate code still covers full speed, the smallest even divisor and larger ones. A mid-loop rewrite of the rate and the length then shows that the old tick spacing holds until the wrap and that the sequence does not restart.

// File: rtl/wp_pkg.sv
package wp_pkg;

  // Effective loop length: 0 acts as 1, oversize requests saturate at depth.
  function automatic int unsigned clamp_points(int unsigned req, int unsigned depth);
    if (req == 0) return 1;
    if (req > depth) return depth;
    return req;
  endfunction

  // Divider reload value: the gap between ticks is reload + 1 base cycles.
  function automatic int unsigned div_reload(int unsigned half, bit shorten);
    if (half == 0) return 0;
    return (2 * half) - 1 - (shorten ? 1 : 0);
  endfunction

endpackage

// File: rtl/wp_rst_sync.sv
module wp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sync_q[STAGES-1];

endmodule

// File: rtl/wp_sample_ram.sv
module wp_sample_ram #(
  parameter int DEPTH    = 4096,
  parameter int SAMPLE_W = 12,
  localparam int ADDR_W  = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [SAMPLE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [SAMPLE_W-1:0] rd_data
);

  logic [SAMPLE_W-1:0] mem [DEPTH];

  // Storage array carries no reset; contents survive a block reset.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/wp_divider.sv
module wp_divider #(
  parameter int CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] reload_val,
  output logic             tick
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == '0);
    cnt_d = tick ? reload_val : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/wp_seq.sv
module wp_seq
  import wp_pkg::*;
#(
  parameter int DEPTH   = 4096,
  parameter int HALF_W  = 17,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int NPTS_W = $clog2(DEPTH + 1),
  localparam int CNT_W  = HALF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              npts_we,
  input  logic [NPTS_W-1:0] npts_wdata,
  input  logic              div_we,
  input  logic [HALF_W-1:0] div_half,
  input  logic              div_compat,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] act_last,
  output logic [HALF_W-1:0] act_half,
  output logic              wrap,
  output logic [CNT_W-1:0]  reload_val
);

  // Staged (host-written) settings
  logic [ADDR_W-1:0] pend_last_q, pend_last_d;
  logic [HALF_W-1:0] pend_half_q, pend_half_d;
  logic              pend_cmp_q,  pend_cmp_d;
  // Settings in force for the running loop
  logic [ADDR_W-1:0] act_last_q,  act_last_d;
  logic [HALF_W-1:0] act_half_q,  act_half_d;
  logic              act_cmp_q,   act_cmp_d;
  logic [ADDR_W-1:0] addr_q,      addr_d;

  always_comb begin
    pend_last_d = pend_last_q;
    pend_half_d = pend_half_q;
    pend_cmp_d  = pend_cmp_q;
    if (npts_we) begin
      pend_last_d = ADDR_W'(clamp_points(32'(npts_wdata), DEPTH) - 1);
    end
    if (div_we) begin
      pend_half_d = div_half;
      pend_cmp_d  = div_compat;
    end

    wrap       = tick && (addr_q == act_last_q);
    addr_d     = addr_q;
    act_last_d = act_last_q;
    act_half_d = act_half_q;
    act_cmp_d  = act_cmp_q;
    if (tick) begin
      addr_d = wrap ? '0 : (addr_q + ADDR_W'(1));
    end
    if (wrap) begin
      act_last_d = pend_last_q;
      act_half_d = pend_half_q;
      act_cmp_d  = pend_cmp_q;
    end

    // The gap that starts at the wrap tick is the one the quirk shortens.
    reload_val = CNT_W'(div_reload(32'(act_half_d), wrap && act_cmp_d));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_last_q <= '0;
      pend_half_q <= '0;
      pend_cmp_q  <= 1'b0;
      act_last_q  <= '0;
      act_half_q  <= '0;
      act_cmp_q   <= 1'b0;
      addr_q      <= '0;
    end else begin
      pend_last_q <= pend_last_d;
      pend_half_q <= pend_half_d;
      pend_cmp_q  <= pend_cmp_d;
      act_last_q  <= act_last_d;
      act_half_q  <= act_half_d;
      act_cmp_q   <= act_cmp_d;
      addr_q      <= addr_d;
    end
  end

  assign rd_addr  = addr_q;
  assign act_last = act_last_q;
  assign act_half = act_half_q;

endmodule

// File: rtl/wave_player.sv
module wave_player #(
  parameter int DEPTH    = 4096,
  parameter int SAMPLE_W = 12,
  parameter int HALF_W   = 17,
  localparam int ADDR_W  = $clog2(DEPTH),
  localparam int NPTS_W  = $clog2(DEPTH + 1),
  localparam int CNT_W   = HALF_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_en,
  input  logic                mem_we,
  input  logic [ADDR_W-1:0]   mem_addr,
  input  logic [SAMPLE_W-1:0] mem_wdata,
  input  logic                npts_we,
  input  logic [NPTS_W-1:0]   npts_wdata,
  input  logic                div_we,
  input  logic [HALF_W-1:0]   div_half,
  input  logic                div_compat,
  output logic [SAMPLE_W-1:0] dac_data,
  output logic                dac_valid,
  output logic                dac_sync
);

  logic                rst_sn;
  logic                tick;
  logic                wrap;
  logic [CNT_W-1:0]    reload_val;
  logic [ADDR_W-1:0]   rd_addr;
  logic [ADDR_W-1:0]   act_last;
  logic [HALF_W-1:0]   act_half;
  logic [SAMPLE_W-1:0] rd_data;
  logic                ram_we;

  logic [SAMPLE_W-1:0] data_q, data_d;
  logic                valid_q, valid_d;
  logic                sync_q, sync_d;

  wp_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  assign ram_we = mem_we && load_en;

  wp_sample_ram #(.DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W)) u_ram (
    .clk     (clk),
    .wr_en   (ram_we),
    .wr_addr (mem_addr),
    .wr_data (mem_wdata),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  wp_divider #(.CNT_W(CNT_W)) u_div (
    .clk        (clk),
    .rst_n      (rst_sn),
    .reload_val (reload_val),
    .tick       (tick)
  );

  wp_seq #(.DEPTH(DEPTH), .HALF_W(HALF_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sn),
    .tick       (tick),
    .npts_we    (npts_we),
    .npts_wdata (npts_wdata),
    .div_we     (div_we),
    .div_half   (div_half),
    .div_compat (div_compat),
    .rd_addr    (rd_addr),
    .act_last   (act_last),
    .act_half   (act_half),
    .wrap       (wrap),
    .reload_val (reload_val)
  );

  always_comb begin
    data_d  = tick ? rd_data : data_q;
    valid_d = tick;
    sync_d  = tick && (rd_addr == '0);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      data_q  <= data_d;
      valid_q <= valid_d;
      sync_q  <= sync_d;
    end
  end

  assign dac_data  = data_q;
  assign dac_valid = valid_q;
  assign dac_sync  = sync_q;

endmodule

// File: rtl/wp_chk.sv
module wp_chk #(
  parameter int ADDR_W = 12,
  parameter int HALF_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wrap,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [ADDR_W-1:0] act_last,
  input logic [HALF_W-1:0] act_half,
  input logic              dac_valid,
  input logic              dac_sync
);

  // R2: the address never leaves the active loop
  p_addr_in_loop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr <= act_last);

  // R2: the tick on the last active address returns to address 0
  p_wrap_to_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rd_addr == act_last) |=> (rd_addr == '0));

  // R4: full speed ticks on every cycle away from a wrap
  p_full_speed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && act_half == '0 && !wrap) |=> tick);

  // R6: active settings hold between wraps
  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && rd_addr == act_last) |=> ($stable(act_last) && $stable(act_half)));

  // R7: sync only together with a valid sample
  p_sync_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dac_sync |-> dac_valid);

  // R7: emitting address 0 raises sync on the next cycle
  p_sync_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rd_addr == '0) |=> dac_sync);

endmodule

bind wave_player wp_chk #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sn),
  .tick      (tick),
  .wrap      (wrap),
  .rd_addr   (rd_addr),
  .act_last  (act_last),
  .act_half  (act_half),
  .dac_valid (dac_valid),
  .dac_sync  (dac_sync)
);

// File: tb/wave_player_tb.sv
module wave_player_tb;

  localparam int DEPTH = 16;
  localparam int SW    = 8;
  localparam int HW    = 4;
  localparam int AW    = 4;
  localparam int NW    = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          load_en, mem_we, npts_we, div_we, div_compat;
  logic [AW-1:0] mem_addr;
  logic [SW-1:0] mem_wdata;
  logic [NW-1:0] npts_wdata;
  logic [HW-1:0] div_half;
  logic [SW-1:0] dac_data;
  logic          dac_valid, dac_sync;

  always #5 clk = ~clk;

  wave_player #(.DEPTH(DEPTH), .SAMPLE_W(SW), .HALF_W(HW)) u_dut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .npts_we(npts_we),
    .npts_wdata(npts_wdata), .div_we(div_we), .div_half(div_half),
    .div_compat(div_compat), .dac_data(dac_data), .dac_valid(dac_valid),
    .dac_sync(dac_sync)
  );

  int errors = 0;
  int checks = 0;
  logic [SW-1:0] model [DEPTH];

  typedef struct packed {
    logic [3:0] half;
    logic [4:0] npts;
    logic       compat;
    logic [7:0] exp_n;
    logic [7:0] exp_per;
  } vec_t;

  // rate code, requested length, flag, expected samples per loop, loop cycles
  localparam vec_t VECS [11] = '{
    '{4'd0, 5'd4,  1'b0, 8'd4,  8'd4},
    '{4'd1, 5'd4,  1'b0, 8'd4,  8'd8},
    '{4'd3, 5'd5,  1'b0, 8'd5,  8'd30},
    '{4'd3, 5'd5,  1'b1, 8'd5,  8'd29},
    '{4'd0, 5'd6,  1'b1, 8'd6,  8'd6},
    '{4'd2, 5'd0,  1'b0, 8'd1,  8'd4},
    '{4'd2, 5'd0,  1'b1, 8'd1,  8'd3},
    '{4'd1, 5'd17, 1'b0, 8'd16, 8'd32},
    '{4'd1, 5'd31, 1'b1, 8'd16, 8'd31},
    '{4'd0, 5'd16, 1'b0, 8'd16, 8'd16},
    '{4'd5, 5'd3,  1'b0, 8'd3,  8'd30}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_sync();
    do @(negedge clk); while (!dac_sync);
  endtask

  task automatic set_cfg(input int half, input int npts, input bit cmp);
    @(negedge clk);
    npts_we = 1'b1; npts_wdata = NW'(npts);
    div_we = 1'b1; div_half = HW'(half); div_compat = cmp;
    @(negedge clk);
    npts_we = 1'b0; div_we = 1'b0;
  endtask

  task automatic mem_write(input int addr, input logic [SW-1:0] data, input bit lock);
    @(negedge clk);
    load_en = lock; mem_we = 1'b1; mem_addr = AW'(addr); mem_wdata = data;
    @(negedge clk);
    mem_we = 1'b0; load_en = 1'b0;
    if (lock) model[addr] = data;
  endtask

  // Measures one full loop under settled settings: period, sample count, order.
  task automatic measure(input int exp_n, input int exp_per, input string tag);
    int cyc, idx, bad;
    wait_sync();
    wait_sync();
    cyc = 0; idx = 1; bad = 0;
    check(dac_valid, {tag, " R7 sync with valid"}, int'(dac_valid), 1);
    if (dac_data !== model[0]) bad++;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (dac_sync) break;
      if (dac_valid) begin
        if (idx < DEPTH && dac_data !== model[idx]) bad++;
        idx++;
      end
    end
    check(cyc == exp_per, {tag, " loop period"}, cyc, exp_per);
    check(idx == exp_n, {tag, " R7 samples per sync"}, idx, exp_n);
    check(bad == 0, {tag, " R2 sample order"}, bad, 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; load_en = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0;
    npts_we = 1'b0; npts_wdata = '0; div_we = 1'b0; div_half = '0; div_compat = 1'b0;
    repeat (3) @(negedge clk);
    // R8: reset state at the ports
    check(dac_valid == 1'b0, "R8 reset valid", int'(dac_valid), 0);
    check(dac_sync == 1'b0, "R8 reset sync", int'(dac_sync), 0);
    check(dac_data == '0, "R8 reset data", int'(dac_data), 0);
    for (int i = 0; i < DEPTH; i++) mem_write(i, SW'(i * 37 + 11), 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    measure(1, 1, "R8 default length 1 full speed");

    // R1: locked write ignored, unlocked write stored
    mem_write(2, ~model[2], 1'b0);
    set_cfg(0, 4, 1'b0);
    measure(4, 4, "R1 locked write ignored");
    mem_write(3, 8'hA5, 1'b1);
    measure(4, 4, "R1 unlocked write stored");

    // R2/R3/R4/R5: vector table
    for (int i = 0; i < 11; i++) begin
      set_cfg(int'(VECS[i].half), int'(VECS[i].npts), VECS[i].compat);
      measure(int'(VECS[i].exp_n), int'(VECS[i].exp_per),
              $sformatf("R2/R3/R4/R5 vector %0d", i));
    end

    // R6: mid-loop rewrite keeps old spacing and length, no restart
    begin
      int k, cyc, idx;
      set_cfg(2, 16, 1'b0);
      wait_sync();
      wait_sync();
      k = 1;
      while (k < 6) begin
        @(negedge clk);
        if (dac_valid) k++;
      end
      div_we = 1'b1; div_half = HW'(1); div_compat = 1'b0;
      npts_we = 1'b1; npts_wdata = NW'(4);
      cyc = 0;
      do begin
        @(negedge clk);
        cyc++;
        if (cyc == 1) begin div_we = 1'b0; npts_we = 1'b0; end
      end while (!dac_valid);
      check(cyc == 4, "R6 old divisor holds mid-loop", cyc, 4);
      check(dac_data == model[6] && !dac_sync, "R6 no restart on write",
            int'(dac_data), int'(model[6]));
      idx = 7;
      while (1) begin
        @(negedge clk);
        if (dac_sync) break;
        if (dac_valid) idx++;
      end
      check(idx == 16, "R6 old length finishes loop", idx, 16);
      measure(4, 8, "R6 new settings after wrap");
    end

    // R8: asynchronous reset mid-run, then defaults return
    set_cfg(1, 5, 1'b0);
    wait_sync();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(dac_valid == 1'b0 && dac_sync == 1'b0, "R8 async reset clears flags",
          int'(dac_valid) + int'(dac_sync), 0);
    check(dac_data == '0, "R8 async reset clears data", int'(dac_data), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    measure(1, 1, "R8 settings revert");

    finish_run();
  end

endmodule